// File: doc/BRIEF.md
# Fractional X/Y Audio Clock Divider

This block derives the bit clock of an audio serial channel from a faster base clock using a rational ratio. A 16-bit rate word holds a numerator X and a denominator Y. From these, an accumulator produces a one-cycle tick at the fractional rate base × X / Y. Each tick flips a bit-clock level, so the serial bit clock runs at half the tick rate. Software picks X and Y so that the tick rate is twice the wanted bit rate. The bit rate is the sample rate × 2 channels × bits per word.

The rate word is loaded by a one-cycle write strobe. Every write restarts the divider phase. A rate word with a zero field stops the clock. A ratio above one cannot be met and is clamped to one tick per base cycle. Everything runs in the base clock domain.

Top module: `fxd_frac_clkdiv`

## Requirements
- R1: On a cycle with `rate_wr` high, X is taken from `rate_wdata[15:8]` and Y from `rate_wdata[7:0]`. Data presented while `rate_wr` is low is ignored.
- R2: After a write with 1 ≤ X ≤ Y, the number of ticks seen in the first k cycles following the write cycle is floor(k·X/Y).
- R3: With 1 ≤ X ≤ Y, `frac_tick` is high k cycles after the write exactly when floor(k·X/Y) exceeds floor((k−1)·X/Y). The internal remainder stays below Y.
- R4: `bclk` inverts on every cycle in which `frac_tick` is high and holds otherwise. It therefore runs at half the tick rate.
- R5: While X or Y is zero, `frac_tick` stays low and `bclk` holds its level.
- R6: While X > Y, `frac_tick` is high on every cycle after the write cycle.
- R7: A write clears the divider phase. In the following cycle `frac_tick` and `bclk` are both low, even when it is written in mid-stream.
- R8: After reset the rate word is zero, `frac_tick` is low and `bclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_wr | input | 1 | Rate word write strobe |
| rate_wdata | input | 16 | Rate word: X in [15:8], Y in [7:0] |
| frac_tick | output | 1 | One-cycle tick at base × X / Y |
| bclk | output | 1 | Serial bit clock, half the tick rate |

## Verification
A write is captured at the clock edge where `rate_wr` is high. That same edge clears the phase, so the outputs read low one cycle later. The tick for step k of the new ratio is registered, so it is visible exactly k cycles after the write edge. `bclk` changes on the same edge as the tick that causes it. The bench samples at the falling edge and numbers each sample by the cycles since the write. It compares the sample with the closed-form floor(k·X/Y) pattern and its parity. The window counts are checked against the same formula at the last sampled step.

// File: rtl/fxd_pkg.sv
package fxd_pkg;
  localparam int RATE_FIELD_W = 8;

  typedef enum logic [1:0] {
    MODE_HALT  = 2'd0,
    MODE_FRAC  = 2'd1,
    MODE_CLAMP = 2'd2
  } div_mode_e;
endpackage

// File: rtl/fxd_rate_reg.sv
module fxd_rate_reg
  import fxd_pkg::*;
#(
  parameter int FW = RATE_FIELD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2*FW-1:0] wdata,
  output logic [FW-1:0]   num_x,
  output logic [FW-1:0]   den_y,
  output div_mode_e       mode,
  output logic            restart
);
  logic [FW-1:0] x_q, y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (wr) begin
      x_q <= wdata[2*FW-1:FW];
      y_q <= wdata[FW-1:0];
    end
  end

  function automatic div_mode_e pick_mode(input logic [FW-1:0] x, input logic [FW-1:0] y);
    if (x == '0 || y == '0) return MODE_HALT;
    if (x > y)              return MODE_CLAMP;
    return MODE_FRAC;
  endfunction

  assign num_x   = x_q;
  assign den_y   = y_q;
  assign mode    = pick_mode(x_q, y_q);
  assign restart = wr;
endmodule

// File: rtl/fxd_accum.sv
module fxd_accum
  import fxd_pkg::*;
#(
  parameter int FW = RATE_FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  div_mode_e     mode,
  input  logic [FW-1:0] num_x,
  input  logic [FW-1:0] den_y,
  output logic          tick,
  output logic [FW-1:0] acc
);
  localparam int SW = FW + 1;

  logic [FW-1:0] acc_q, acc_n;
  logic          tick_q, tick_n;
  logic [SW-1:0] sum, rem;
  logic          hit;

  function automatic logic [SW-1:0] add_step(input logic [FW-1:0] a, input logic [FW-1:0] x);
    return {1'b0, a} + {1'b0, x};
  endfunction

  always_comb begin
    sum    = add_step(acc_q, num_x);
    rem    = sum - {1'b0, den_y};
    hit    = (sum >= {1'b0, den_y});
    acc_n  = acc_q;
    tick_n = 1'b0;
    unique case (mode)
      MODE_FRAC: begin
        tick_n = hit;
        acc_n  = hit ? rem[FW-1:0] : sum[FW-1:0];
      end
      MODE_CLAMP: begin
        tick_n = 1'b1;
        acc_n  = '0;
      end
      default: begin
        tick_n = 1'b0;
        acc_n  = acc_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;
  assign acc  = acc_q;
endmodule

// File: rtl/fxd_halver.sv
module fxd_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick_next,
  output logic half_clk
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) lvl_q <= 1'b0;
    else if (tick_next)    lvl_q <= ~lvl_q;
  end

  assign half_clk = lvl_q;
endmodule

// File: rtl/fxd_frac_clkdiv.sv
module fxd_frac_clkdiv
  import fxd_pkg::*;
#(
  parameter int FW = RATE_FIELD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_wr,
  input  logic [2*FW-1:0] rate_wdata,
  output logic            frac_tick,
  output logic            bclk
);
  logic [FW-1:0] x_w, y_w, acc_w;
  div_mode_e     mode_w;
  logic          restart_w;
  logic          tick_w;
  logic          tick_next_w;

  fxd_rate_reg #(.FW(FW)) u_rate (
    .clk(clk), .rst_n(rst_n), .wr(rate_wr), .wdata(rate_wdata),
    .num_x(x_w), .den_y(y_w), .mode(mode_w), .restart(restart_w)
  );

  fxd_accum #(.FW(FW)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(restart_w), .mode(mode_w),
    .num_x(x_w), .den_y(y_w), .tick(tick_w), .acc(acc_w)
  );

  // The halver toggles on the same edge that registers the tick.
  assign tick_next_w = (mode_w == MODE_CLAMP) ||
                       ((mode_w == MODE_FRAC) &&
                        (({1'b0, acc_w} + {1'b0, x_w}) >= {1'b0, y_w}));

  fxd_halver u_half (
    .clk(clk), .rst_n(rst_n), .restart(restart_w),
    .tick_next(tick_next_w), .half_clk(bclk)
  );

  assign frac_tick = tick_w;
endmodule

// File: rtl/fxd_frac_clkdiv_chk.sv
module fxd_frac_clkdiv_chk
  import fxd_pkg::*;
#(
  parameter int FW = RATE_FIELD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rate_wr,
  input logic          frac_tick,
  input logic          bclk,
  input div_mode_e     mode_w,
  input logic [FW-1:0] acc_w,
  input logic [FW-1:0] y_w
);
  a_r3_acc_below_y: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_FRAC) |-> (acc_w < y_w));

  a_r4_bclk_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_wr |=> ((bclk != $past(bclk)) == frac_tick));

  a_r5_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_wr && mode_w == MODE_HALT) |=> (!frac_tick && $stable(bclk)));

  a_r6_clamp_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_wr && mode_w == MODE_CLAMP) |=> frac_tick);

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (!frac_tick && !bclk));
endmodule

bind fxd_frac_clkdiv fxd_frac_clkdiv_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .frac_tick(frac_tick),
  .bclk(bclk), .mode_w(mode_w), .acc_w(acc_w), .y_w(y_w)
);

// File: tb/test_fxd_frac_clkdiv.sv
module test_fxd_frac_clkdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_wr = 1'b0;
  logic [15:0] rate_wdata = '0;
  logic        frac_tick, bclk;

  int    checks = 0, fails = 0;
  int    mx = 0, my = 0, k = 0, k_s = 0, seen = 0;
  logic  exp_tick = 1'b0, exp_bclk = 1'b0;
  string req = "R8";

  always #2 clk = ~clk;

  fxd_frac_clkdiv i_fxd_frac_clkdiv (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .frac_tick(frac_tick), .bclk(bclk)
  );

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d, X=%0d Y=%0d)", r, act, exp, k_s, mx, my);
    end
  endtask

  // Compare at the falling edge, then drive and predict the state after the next rising edge.
  task automatic cyc(input logic wr, input logic [15:0] d);
    @(negedge clk);
    check(req, int'(frac_tick), int'(exp_tick));
    check("R4", int'(bclk), int'(exp_bclk));
    seen += int'(frac_tick);
    k_s = k;
    rate_wr = wr;
    rate_wdata = d;
    if (wr) begin
      mx = int'(d[15:8]); my = int'(d[7:0]);
      k = 0; exp_tick = 1'b0; exp_bclk = 1'b0; seen = 0;
    end else begin
      k++;
      if (mx == 0 || my == 0) begin
        exp_tick = 1'b0;
      end else if (mx > my) begin
        exp_tick = 1'b1;
        exp_bclk = logic'(k % 2);
      end else begin
        exp_tick = ((k * mx) / my) != (((k - 1) * mx) / my);
        exp_bclk = logic'(((k * mx) / my) % 2);
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'(i * 16'h3b1d));
  endtask

  task automatic window(input string r);
    int e;
    if (mx > my) e = k_s;
    else if (mx == 0 || my == 0) e = 0;
    else e = (k_s * mx) / my;
    check(r, seen, e);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    req = "R8";
    run(4);
    @(negedge clk) rst_n = 1'b1;
    run(6);
    window("R8");

    // R1, R3: X=3 Y=5 while junk data rides with strobe low
    req = "R3";
    cyc(1'b1, 16'h0305);
    run(41);
    window("R2");

    // R2: slow ratio 1/254
    req = "R2";
    cyc(1'b1, 16'h01FE);
    run(600);
    window("R2");

    // R1: field order, 0x0102 is half rate, 0x0201 clamps
    req = "R1";
    cyc(1'b1, 16'h0102);
    run(20);
    window("R1");
    req = "R6";
    cyc(1'b1, 16'h0201);
    run(15);
    window("R6");
    cyc(1'b1, 16'h0903);
    run(12);

    // X equal to Y: tick every cycle
    req = "R3";
    cyc(1'b1, 16'h0707);
    run(10);
    window("R3");
    cyc(1'b1, 16'hFDFE);
    run(300);
    window("R2");

    // R7: restart in mid-stream
    req = "R7";
    cyc(1'b1, 16'h0207);
    run(5);
    cyc(1'b1, 16'h0207);
    run(30);
    window("R7");

    // R5: zero word, then zero Y only, then zero X only
    req = "R5";
    cyc(1'b1, 16'h0305);
    run(3);
    cyc(1'b1, 16'h0000);
    run(20);
    window("R5");
    cyc(1'b1, 16'h0500);
    run(20);
    cyc(1'b1, 16'h0009);
    run(20);
    window("R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule